// File: doc/BRIEF.md
# Master Video Sync Timing Generator

This block is the timing master for a digital video encoder. It runs on the byte clock of a multiplexed pixel stream in which the bytes repeat as Cb, Y, Cr, Y. It counts byte positions within a line and lines within a frame. From those counts it drives active-low horizontal and vertical sync, a field flag, a vertical-blanking flag, and the live line and sample counts for downstream stages.

A format input picks 525-line or 625-line timing. The field type is encoded by the phase between the two sync falling edges. An odd field starts where the vertical sync falls together with the horizontal sync. An even field starts where the vertical sync falls at mid-line, while the horizontal sync is high. In 625-line mode the vertical sync is two and a half lines wide. A control input suppresses the blanking flag so that the vertical interval can carry picture data.

The format should change only while reset is held. If it changes while the block is running, the counters still wrap safely on the next line or frame boundary. After reset is released, the counters hold for one clock and then start at line 1, sample 0.

Top module: `vid_sync_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is line 1, sample 0, with `hsync_n` and `vsync_n` both high. After release, one clock passes with the counters held before counting starts.
- R2: The sample counter runs from 0 to LEN-1 and then wraps. LEN is `LEN_525` when `fmt_625`=0 and `LEN_625` when `fmt_625`=1. Each wrap advances the line counter, which runs from 1 to 525 (`fmt_625`=0) or 1 to 625 (`fmt_625`=1) and then returns to 1.
- R3: `hsync_n` is low for samples 0 to `HS_BYTES`-1 of every line, which is 64 pixels at the default. Its falling edge is therefore at sample 0, a Cb slot, whose index is a multiple of 4.
- R4: In 525-line mode, the odd-field vertical sync is low from line 4 sample 0 up to, but not including, line 7 sample 0. Its falling edge coincides with the falling edge of `hsync_n`.
- R5: In 525-line mode, the even-field vertical sync is low from line 266 sample LEN/2 up to line 269 sample LEN/2, a width of 3 lines. It falls while `hsync_n` is high.
- R6: In 625-line mode, the odd-field vertical sync is low from line 1 sample 0 up to line 3 sample LEN/2, a width of 2.5 lines. It falls together with `hsync_n`.
- R7: In 625-line mode, the even-field vertical sync is low from line 313 sample LEN/2 up to line 316 sample 0, a width of 2.5 lines. It falls while `hsync_n` is high.
- R8: `field_even` is 0 on lines 1 to 263 (525) or 1 to 312 (625), and 1 on all later lines. It therefore changes at each field boundary.
- R9: With `vbi_off`=0 in 525-line mode, `vblank` is 1 on lines 1 to 21, 262 to 284 and 525, and 0 on all other lines.
- R10: With `vbi_off`=0 in 625-line mode, `vblank` is 1 on lines 1 to 22, 311 to 335, 624 and 625, and 0 on all other lines.
- R11: With `vbi_off`=1, `vblank` is 0 on every line in both formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| vbi_off | input | 1 | 1 keeps the blanking flag inactive |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_even | output | 1 | 0 in the odd field, 1 in the even field |
| vblank | output | 1 | Vertical blanking flag, active high |
| line_num | output | 10 | Current line, 1-based |
| sample_cnt | output | $clog2(LEN_625) | Byte position within the line |

## Verification
The hardest situations to reach from the ports are the even-field vertical sync edges at mid-line and the frame wrap from line 525 or 625 back to 1. At real line lengths, a single frame takes close to a million clocks. The bench therefore shrinks the line lengths and the sync width through parameters so that whole frames fit. It then runs two complete frames in each format from reset, comparing every output on every clock against a model built from the requirements. Resets between the runs also exercise reset from the middle of a frame.

// File: rtl/vid_sync_master.sv
module vid_sync_master #(
  parameter int LEN_525  = 1716,
  parameter int LEN_625  = 1728,
  parameter int HS_BYTES = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fmt_625,
  input  logic                        vbi_off,
  output logic                        hsync_n,
  output logic                        vsync_n,
  output logic                        field_even,
  output logic                        vblank,
  output logic [9:0]                  line_num,
  output logic [$clog2(LEN_625)-1:0]  sample_cnt
);
  localparam int SW = $clog2(LEN_625);
  localparam int LW = 10;
  localparam int PW = $clog2(625 * LEN_625 + 1);

  logic          run;
  logic [LW-1:0] line_q;
  logic [SW-1:0] samp_q;
  logic [SW-1:0] len_m1;
  logic [LW-1:0] last_line;
  logic [PW-1:0] len_p, half_p, pos;
  logic          eol, vs_win, vb_525, vb_625;

  assign len_m1    = fmt_625 ? SW'(LEN_625 - 1) : SW'(LEN_525 - 1);
  assign last_line = fmt_625 ? LW'(625) : LW'(525);
  assign eol       = samp_q >= len_m1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      line_q <= LW'(1);
      samp_q <= '0;
    end else begin
      run <= 1'b1;
      if (run) begin
        if (eol) begin
          samp_q <= '0;
          line_q <= (line_q >= last_line) ? LW'(1) : line_q + 1'b1;
        end else begin
          samp_q <= samp_q + 1'b1;
        end
      end
    end
  end

  assign len_p  = fmt_625 ? PW'(LEN_625) : PW'(LEN_525);
  assign half_p = len_p >> 1;
  assign pos    = PW'(line_q - 1'b1) * len_p + PW'(samp_q);

  always_comb begin
    if (fmt_625)
      vs_win = (pos < PW'(2) * len_p + half_p) ||
               (pos >= PW'(312) * len_p + half_p && pos < PW'(315) * len_p);
    else
      vs_win = (pos >= PW'(3) * len_p && pos < PW'(6) * len_p) ||
               (pos >= PW'(265) * len_p + half_p && pos < PW'(268) * len_p + half_p);
  end

  assign vb_525 = (line_q <= LW'(21)) || (line_q >= LW'(262) && line_q <= LW'(284)) ||
                  (line_q == LW'(525));
  assign vb_625 = (line_q <= LW'(22)) || (line_q >= LW'(311) && line_q <= LW'(335)) ||
                  (line_q >= LW'(624));

  assign hsync_n    = !(run && samp_q < SW'(HS_BYTES));
  assign vsync_n    = !(run && vs_win);
  assign field_even = fmt_625 ? (line_q >= LW'(313)) : (line_q >= LW'(264));
  assign vblank     = !vbi_off && (fmt_625 ? vb_625 : vb_525);
  assign line_num   = line_q;
  assign sample_cnt = samp_q;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (line_num == LW'(1) && sample_cnt == '0 && hsync_n && vsync_n)); // R1

  AST_SAMPLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sample_cnt == len_m1) |=> (sample_cnt == '0)); // R2

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && eol && line_num == last_line) |=> (line_num == LW'(1))); // R2

  AST_HS_CB_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> (sample_cnt[1:0] == 2'b00)); // R3

  AST_ODD_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) && !field_even) |-> $fell(hsync_n)); // R4

  AST_EVEN_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) && field_even) |-> hsync_n); // R5

  AST_FIELD_ODD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num == LW'(1)) |-> !field_even); // R8
endmodule

// File: tb/vid_sync_master_bench.sv
module vid_sync_master_bench;
  localparam int PERIOD = 10;
  localparam int L525   = 40;
  localparam int L625   = 48;
  localparam int HSB    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_625 = 1'b0;
  logic vbi_off = 1'b0;
  logic hsync_n, vsync_n, field_even, vblank;
  logic [9:0] line_num;
  logic [$clog2(L625)-1:0] sample_cnt;

  int n_cmp = 0;
  int n_bad = 0;

  vid_sync_master #(.LEN_525(L525), .LEN_625(L625), .HS_BYTES(HSB)) u_vid_sync_master (
    .clk(clk), .rst_n(rst_n), .fmt_625(fmt_625), .vbi_off(vbi_off),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .field_even(field_even),
    .vblank(vblank), .line_num(line_num), .sample_cnt(sample_cnt));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit f, input bit vo);
    @(negedge clk);
    rst_n = 1'b0; fmt_625 = f; vbi_off = vo;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "line after reset", int'(line_num), 1);
    check("R1", "sample after reset", int'(sample_cnt), 0);
    check("R1", "hsync_n in reset", int'(hsync_n), 1);
    check("R1", "vsync_n in reset", int'(vsync_n), 1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "line held one clock", int'(line_num), 1);
    check("R1", "sample held one clock", int'(sample_cnt), 0);
  endtask

  function automatic bit exp_vs(input bit f, input int ln, input int sm);
    int len = f ? L625 : L525;
    int h = len / 2;
    int p = (ln - 1) * len + sm;
    if (f)
      return (p < 2*len + h) || (p >= 312*len + h && p < 315*len);
    else
      return (p >= 3*len && p < 6*len) || (p >= 265*len + h && p < 268*len + h);
  endfunction

  function automatic bit exp_vb(input bit f, input bit vo, input int ln);
    if (vo) return 1'b0;
    if (f) return (ln <= 22) || (ln >= 311 && ln <= 335) || (ln >= 624);
    return (ln <= 21) || (ln >= 262 && ln <= 284) || (ln == 525);
  endfunction

  task automatic sweep(input bit f, input bit vo, input int cycles);
    int len = f ? L625 : L525;
    int nl = f ? 625 : 525;
    int el = 1;
    int es = 0;
    string rv = f ? "R6/R7" : "R4/R5";
    string rb = vo ? "R11" : (f ? "R10" : "R9");
    do_reset(f, vo);
    for (int i = 0; i < cycles; i++) begin
      if (i != 0) @(negedge clk);
      check("R2", "line", int'(line_num), el);
      check("R2", "sample", int'(sample_cnt), es);
      check("R3", "hsync_n", int'(hsync_n), (es < HSB) ? 0 : 1);
      check(rv, "vsync_n", int'(vsync_n), exp_vs(f, el, es) ? 0 : 1);
      check("R8", "field_even", int'(field_even), (el >= (f ? 313 : 264)) ? 1 : 0);
      check(rb, "vblank", int'(vblank), int'(exp_vb(f, vo, el)));
      if (es == len - 1) begin
        es = 0;
        el = (el == nl) ? 1 : el + 1;
      end else begin
        es++;
      end
    end
  endtask

  task automatic t_525_frames;   sweep(1'b0, 1'b0, 2 * 525 * L525 + 3 * L525); endtask
  task automatic t_625_frames;   sweep(1'b1, 1'b0, 2 * 625 * L625 + 3 * L625); endtask
  task automatic t_525_vbi_off;  sweep(1'b0, 1'b1, 30 * L525); endtask
  task automatic t_625_vbi_off;  sweep(1'b1, 1'b1, 30 * L625); endtask

  initial begin
    #(PERIOD * 180000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_525_frames();
    t_625_vbi_off();
    t_625_frames();
    t_525_vbi_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule